// File: doc/BRIEF.md
# Phase-Shifted Full-Bridge Gate Sequencer

This block generates the four gate-drive signals of a full-bridge power stage as two legs, each a complementary pair. Every leg switches at a fixed half-and-half duty cycle. The A-B leg is tied to an internal period counter. The C-D leg runs the same waveform delayed by a commanded number of ticks. Power is set by that phase delay, not by pulse width. Each leg has its own dead time, which holds off the turn-on of one switch after its partner turns off.

The period, the phase command and both dead times are captured once per switching period, at the counter wrap. A change written mid-period therefore cannot shorten a pulse that is already running. A force-off input removes all four drives in the same cycle, without gating the clock. The counter keeps running, and switching resumes in step once force-off drops. A one-tick strobe marks the first tick of every period for downstream logic.

Top module: `psfb_pwm`

## Requirements
- R1: The period is max(period_i, 4) ticks, captured at the wrap. cyc_start_o is high for exactly the first tick of each period. In the first cycle after reset release, the counter is at tick 0 and cyc_start_o is high.
- R2: Let P be the captured period, H = floor(P/2) and j the tick index (j = 0 on the strobe tick). With one tick of latency, the A-B leg has A on the side for ticks 0..H-1 and B on the side for ticks H..P-1. A is high for H - dt_ab ticks per period and B for P - H - dt_ab ticks.
- R3: After one switch of a leg turns off, its partner turns on exactly dt ticks later. dt is dt_ab_i for A-B and dt_cd_i for C-D, set independently. A therefore first rises at j = 1 + dt_ab.
- R4: gate_a_o and gate_b_o are never high together, and neither are gate_c_o and gate_d_o.
- R5: The C-D leg is the A-B waveform delayed by the effective phase ph. C has the same on-time formula as A, using dt_cd. C rises at j = (ph + 1 + dt_cd) mod P.
- R6: A phase command below 2 gives ph = 0, so C-D switches in step with A-B. A command above H gives ph = H (full power).
- R7: Changes to the period, phase or dead-time inputs during a period have no effect until the next strobe.
- R8: While force_off_i is high, all four gates are low in that same cycle. The period counter and leg timing continue unaffected, so releasing force-off restores the gates that are due at that point.
- R9: While rst_n is low, all four gates and cyc_start_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Switching tick clock |
| rst_n | input | 1 | Synchronous active-low reset |
| period_i | input | CNT_W | Period in ticks (floored at 4) |
| phase_i | input | CNT_W | Phase delay of the C-D leg in ticks |
| dt_ab_i | input | DT_W | Dead time of the A-B leg in ticks |
| dt_cd_i | input | DT_W | Dead time of the C-D leg in ticks |
| force_off_i | input | 1 | Forces all four gates low at once |
| gate_a_o | output | 1 | A-B leg, first-half switch |
| gate_b_o | output | 1 | A-B leg, second-half switch |
| gate_c_o | output | 1 | C-D leg, first-half switch |
| gate_d_o | output | 1 | C-D leg, second-half switch |
| cyc_start_o | output | 1 | One-tick strobe at the start of each period |

## Verification
Two events can land on the same tick. Force-off can arrive on the exact tick that a leg's dead time expires and A and C are due to rise. A new phase and period can be written on the strobe tick itself, just after the previous capture. The bench raises force-off on the tick where A first goes high and checks that all four gates drop in that sample. It then releases force-off and expects A and C back on at once. For the second case it rewrites the timing inputs on a strobe tick, then measures that period's length and C rise against the old values and the next period's against the new ones.

// File: rtl/psfb_pkg.sv
// Shared constants and types for the phase-shifted bridge sequencer.
// Assumes exactly two legs; leg 0 is the reference leg, leg 1 the shifted one.
package psfb_pkg;
    localparam int LEG_AB   = 0;
    localparam int LEG_CD   = 1;
    localparam int NUM_LEGS = 2;

    // Drive pair of one leg: hi = first-half switch, lo = second-half switch.
    typedef struct packed {
        logic hi;
        logic lo;
    } leg_drv_t;
endpackage

// File: rtl/psfb_timebase.sv
// Period counter with start-of-period capture of every timing input.
// Assumes PER_MIN >= 4 so the strobe is never on two ticks in a row.
// Inputs are also loaded during reset, so the first period after release
// already runs with the values presented then.
module psfb_timebase #(
    parameter int CNT_W   = 8,
    parameter int DT_W    = 6,
    parameter int PER_MIN = 4
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic [CNT_W-1:0]                           period_i,
    input  logic [CNT_W-1:0]                           phase_i,
    input  logic [DT_W-1:0]                            dt_ab_i,
    input  logic [DT_W-1:0]                            dt_cd_i,
    output logic [CNT_W-1:0]                           cnt_o,
    output logic [CNT_W-1:0]                           per_o,
    output logic [CNT_W-1:0]                           half_o,
    output logic [CNT_W-1:0]                           phase_o,
    output logic [psfb_pkg::NUM_LEGS-1:0][DT_W-1:0]    dt_o,
    output logic                                       start_o
);
    import psfb_pkg::*;

    localparam logic [CNT_W-1:0] PER_FLOOR = CNT_W'(PER_MIN);
    localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

    logic [CNT_W-1:0]                cnt_q;
    logic [CNT_W-1:0]                per_q;
    logic [CNT_W-1:0]                ph_q;
    logic [NUM_LEGS-1:0][DT_W-1:0]   dt_q;
    logic [CNT_W-1:0]                per_req;
    logic                            wrap;

    // Floor the requested period at the minimum legal length.
    always_comb begin
        per_req = (period_i < PER_FLOOR) ? PER_FLOOR : period_i;
    end

    // Last tick of the running period.
    always_comb begin
        wrap = (cnt_q == per_q - ONE);
    end

    // Count ticks, and capture new timing values only on the wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q          <= '0;
            per_q          <= per_req;
            ph_q           <= phase_i;
            dt_q[LEG_AB]   <= dt_ab_i;
            dt_q[LEG_CD]   <= dt_cd_i;
        end else if (wrap) begin
            cnt_q          <= '0;
            per_q          <= per_req;
            ph_q           <= phase_i;
            dt_q[LEG_AB]   <= dt_ab_i;
            dt_q[LEG_CD]   <= dt_cd_i;
        end else begin
            cnt_q          <= cnt_q + ONE;
        end
    end

    // Expose the counter and the captured values.
    always_comb begin
        cnt_o   = cnt_q;
        per_o   = per_q;
        half_o  = per_q >> 1;
        phase_o = ph_q;
        dt_o    = dt_q;
        start_o = (cnt_q == '0);
    end
endmodule

// File: rtl/psfb_phase.sv
// Derives the ideal (dead-time-free) side of each leg from the tick count.
// Leg A-B is on its first side for ticks [0, half). Leg C-D is the same
// pattern delayed by the clamped phase. Assumes cnt < per and half <= per.
module psfb_phase #(
    parameter int CNT_W  = 8,
    parameter int PH_MIN = 2
) (
    input  logic [CNT_W-1:0]                 cnt_i,
    input  logic [CNT_W-1:0]                 per_i,
    input  logic [CNT_W-1:0]                 half_i,
    input  logic [CNT_W-1:0]                 phase_i,
    output logic [psfb_pkg::NUM_LEGS-1:0]    side_o
);
    import psfb_pkg::*;

    localparam logic [CNT_W-1:0] PH_FLOOR = CNT_W'(PH_MIN);

    logic [CNT_W-1:0] ph_eff;
    logic [CNT_W-1:0] pos_cd;

    // Small commands collapse to zero shift; large ones saturate at half period.
    always_comb begin
        if (phase_i < PH_FLOOR) begin
            ph_eff = '0;
        end else if (phase_i > half_i) begin
            ph_eff = half_i;
        end else begin
            ph_eff = phase_i;
        end
    end

    // Position of the shifted leg within its own period, modulo the period.
    always_comb begin
        if (cnt_i >= ph_eff) begin
            pos_cd = cnt_i - ph_eff;
        end else begin
            pos_cd = cnt_i + (per_i - ph_eff);
        end
    end

    // First side is active during the first half of each leg's period.
    always_comb begin
        side_o[LEG_AB] = (cnt_i  < half_i);
        side_o[LEG_CD] = (pos_cd < half_i);
    end
endmodule

// File: rtl/psfb_deadband.sv
// Dead-time inserter for one leg. The ideal side is registered, which
// adds one tick of latency, and the time since its last change is counted.
// The switch of the active side turns on only once that age reaches dt.
// The age saturates, so any dt up to its maximum is honoured.
module psfb_deadband #(
    parameter int DT_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            side_i,
    input  logic [DT_W-1:0] dt_i,
    output logic            hi_o,
    output logic            lo_o
);
    localparam logic [DT_W-1:0] AGE_MAX = '1;

    logic            side_q;
    logic [DT_W-1:0] age_q;
    logic            settled;

    // Track the side and how many ticks it has held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            side_q <= 1'b0;
            age_q  <= '0;
        end else if (side_i != side_q) begin
            side_q <= side_i;
            age_q  <= '0;
        end else if (age_q != AGE_MAX) begin
            age_q  <= age_q + DT_W'(1);
        end
    end

    // Enable the active side's switch after the dead time.
    always_comb begin
        settled = (age_q >= dt_i);
        hi_o    = side_q  & settled;
        lo_o    = ~side_q & settled;
    end
endmodule

// File: rtl/psfb_pwm.sv
// Phase-shifted full-bridge gate sequencer: timebase, phase decode, one
// dead-time inserter per leg (generated), and an asynchronous-path
// force-off gate on the outputs. Assumes the clock is the switching tick.
module psfb_pwm #(
    parameter int CNT_W   = 8,
    parameter int DT_W    = 6,
    parameter int PH_MIN  = 2,
    parameter int PER_MIN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] phase_i,
    input  logic [DT_W-1:0]  dt_ab_i,
    input  logic [DT_W-1:0]  dt_cd_i,
    input  logic             force_off_i,
    output logic             gate_a_o,
    output logic             gate_b_o,
    output logic             gate_c_o,
    output logic             gate_d_o,
    output logic             cyc_start_o
);
    import psfb_pkg::*;

    logic [CNT_W-1:0]                cnt;
    logic [CNT_W-1:0]                per;
    logic [CNT_W-1:0]                half;
    logic [CNT_W-1:0]                ph_cap;
    logic [NUM_LEGS-1:0][DT_W-1:0]   dt_cap;
    logic                            start;
    logic [NUM_LEGS-1:0]             side;
    leg_drv_t                        drv [NUM_LEGS];
    logic                            enable;

    psfb_timebase #(
        .CNT_W   (CNT_W),
        .DT_W    (DT_W),
        .PER_MIN (PER_MIN)
    ) i_timebase (
        .clk      (clk),
        .rst_n    (rst_n),
        .period_i (period_i),
        .phase_i  (phase_i),
        .dt_ab_i  (dt_ab_i),
        .dt_cd_i  (dt_cd_i),
        .cnt_o    (cnt),
        .per_o    (per),
        .half_o   (half),
        .phase_o  (ph_cap),
        .dt_o     (dt_cap),
        .start_o  (start)
    );

    psfb_phase #(
        .CNT_W  (CNT_W),
        .PH_MIN (PH_MIN)
    ) i_phase (
        .cnt_i   (cnt),
        .per_i   (per),
        .half_i  (half),
        .phase_i (ph_cap),
        .side_o  (side)
    );

    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
        psfb_deadband #(
            .DT_W (DT_W)
        ) i_deadband (
            .clk    (clk),
            .rst_n  (rst_n),
            .side_i (side[g]),
            .dt_i   (dt_cap[g]),
            .hi_o   (drv[g].hi),
            .lo_o   (drv[g].lo)
        );
    end

    // Outputs are live only out of reset and without force-off.
    always_comb begin
        enable      = rst_n & ~force_off_i;
        gate_a_o    = drv[LEG_AB].hi & enable;
        gate_b_o    = drv[LEG_AB].lo & enable;
        gate_c_o    = drv[LEG_CD].hi & enable;
        gate_d_o    = drv[LEG_CD].lo & enable;
        cyc_start_o = start & rst_n;
    end
endmodule

// Property checker for psfb_pwm; observes top-level ports only.
module psfb_pwm_chk (
    input logic clk,
    input logic rst_n,
    input logic force_off_i,
    input logic gate_a_o,
    input logic gate_b_o,
    input logic gate_c_o,
    input logic gate_d_o,
    input logic cyc_start_o
);
    // R4
    no_shoot_ab_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_a_o && gate_b_o));

    // R4
    no_shoot_cd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_c_o && gate_d_o));

    // R8
    force_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        force_off_i |-> !(gate_a_o || gate_b_o || gate_c_o || gate_d_o));

    // R1
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_start_o |=> !cyc_start_o);

    // R9
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> !(gate_a_o || gate_b_o || gate_c_o || gate_d_o || cyc_start_o));
endmodule

bind psfb_pwm psfb_pwm_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .force_off_i (force_off_i),
    .gate_a_o    (gate_a_o),
    .gate_b_o    (gate_b_o),
    .gate_c_o    (gate_c_o),
    .gate_d_o    (gate_d_o),
    .cyc_start_o (cyc_start_o)
);

// File: tb/test_psfb_pwm.sv
module test_psfb_pwm;
    localparam int CNT_W = 8;
    localparam int DT_W  = 6;
    localparam int NVEC  = 9;
    localparam int WATCHDOG = 150000;

    // {period, phase, dt_ab, dt_cd, len, on_a, on_b, on_c, on_d, rise_a, rise_c}
    localparam int VEC [NVEC][11] = '{
        '{40,   0, 2, 3, 40, 18, 18, 17, 17, 3,  4},
        '{40,  10, 1, 4, 40, 19, 19, 16, 16, 2, 15},
        '{40,  20, 0, 0, 40, 20, 20, 20, 20, 1, 21},
        '{40,   1, 3, 3, 40, 17, 17, 17, 17, 4,  4},
        '{40, 100, 2, 5, 40, 18, 18, 15, 15, 3, 26},
        '{ 2,   0, 0, 1,  4,  2,  2,  1,  1, 1,  2},
        '{31,   7, 2, 2, 31, 13, 14, 13, 14, 3, 10},
        '{64,  30, 5, 9, 64, 27, 27, 23, 23, 6, 40},
        '{40,  25, 4, 4, 40, 16, 16, 16, 16, 5, 25}
    };

    logic             clk = 1'b0;
    logic             rst_n;
    logic [CNT_W-1:0] period_i;
    logic [CNT_W-1:0] phase_i;
    logic [DT_W-1:0]  dt_ab_i;
    logic [DT_W-1:0]  dt_cd_i;
    logic             force_off_i;
    logic             gate_a_o, gate_b_o, gate_c_o, gate_d_o, cyc_start_o;

    int  n_checks = 0;
    int  n_fail   = 0;
    int  cycles   = 0;
    logic prev_a = 1'b0;
    logic prev_c = 1'b0;

    psfb_pwm #(.CNT_W(CNT_W), .DT_W(DT_W)) i_psfb_pwm (
        .clk         (clk),
        .rst_n       (rst_n),
        .period_i    (period_i),
        .phase_i     (phase_i),
        .dt_ab_i     (dt_ab_i),
        .dt_cd_i     (dt_cd_i),
        .force_off_i (force_off_i),
        .gate_a_o    (gate_a_o),
        .gate_b_o    (gate_b_o),
        .gate_c_o    (gate_c_o),
        .gate_d_o    (gate_d_o),
        .cyc_start_o (cyc_start_o)
    );

    always #5 clk = ~clk;

    task automatic chk(input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Watchdog: a hung run is one failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, WATCHDOG);
            summary();
        end
    end

    task automatic tick();
        prev_a = gate_a_o;
        prev_c = gate_c_o;
        @(negedge clk);
    endtask

    task automatic next_start();
        tick();
        while (!cyc_start_o) tick();
    endtask

    // Called on a strobe sample; measures one full period.
    task automatic measure(output int len, output int na, output int nb,
                           output int nc, output int nd, output int ra,
                           output int rc, output int ovl);
        int j;
        j = 0; na = 0; nb = 0; nc = 0; nd = 0; ra = -1; rc = -1; ovl = 0;
        do begin
            na += int'(gate_a_o);
            nb += int'(gate_b_o);
            nc += int'(gate_c_o);
            nd += int'(gate_d_o);
            if ((gate_a_o && gate_b_o) || (gate_c_o && gate_d_o)) ovl++;
            if (gate_a_o && !prev_a && ra < 0) ra = j;
            if (gate_c_o && !prev_c && rc < 0) rc = j;
            tick();
            j++;
        end while (!cyc_start_o);
        len = j;
    endtask

    task automatic apply(input int per, input int ph, input int dab, input int dcd);
        period_i = CNT_W'(per);
        phase_i  = CNT_W'(ph);
        dt_ab_i  = DT_W'(dab);
        dt_cd_i  = DT_W'(dcd);
    endtask

    initial begin
        int len, na, nb, nc, nd, ra, rc, ovl;
        rst_n = 1'b0;
        force_off_i = 1'b0;
        apply(40, 0, 0, 0);
        repeat (3) @(negedge clk);
        // R9: quiet during reset even with zero dead time
        chk("R9 gates during reset", int'({gate_a_o, gate_b_o, gate_c_o, gate_d_o}), 0);
        chk("R9 strobe during reset", int'(cyc_start_o), 0);
        rst_n = 1'b1;
        #1;
        // R1: strobe on the first tick after release
        chk("R1 strobe after reset", int'(cyc_start_o), 1);
        tick();
        chk("R1 strobe one tick only", int'(cyc_start_o), 0);

        // Vector table
        for (int v = 0; v < NVEC; v++) begin
            apply(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);
            next_start();
            next_start();
            measure(len, na, nb, nc, nd, ra, rc, ovl);
            chk($sformatf("R1 period length v%0d", v), len, VEC[v][4]);
            chk($sformatf("R2/R3 A on-time v%0d", v), na, VEC[v][5]);
            chk($sformatf("R2/R3 B on-time v%0d", v), nb, VEC[v][6]);
            chk($sformatf("R5/R3 C on-time v%0d", v), nc, VEC[v][7]);
            chk($sformatf("R5/R3 D on-time v%0d", v), nd, VEC[v][8]);
            chk($sformatf("R3 A rise tick v%0d", v), ra, VEC[v][9]);
            chk($sformatf("R5/R6 C rise tick v%0d", v), rc, VEC[v][10]);
            chk($sformatf("R4 overlap ticks v%0d", v), ovl, 0);
        end

        // R7: inputs rewritten on the strobe tick apply one period later
        apply(40, 15, 2, 2);
        next_start();
        next_start();
        apply(20, 5, 2, 2);
        measure(len, na, nb, nc, nd, ra, rc, ovl);
        chk("R7 old period kept", len, 40);
        chk("R7 old phase kept", rc, 18);
        measure(len, na, nb, nc, nd, ra, rc, ovl);
        chk("R7 new period applied", len, 20);
        chk("R7 new phase applied", rc, 8);

        // R8: force-off on the tick A and C are due to rise
        apply(40, 0, 3, 3);
        next_start();
        next_start();
        repeat (4) tick();
        chk("R8 A due before force", int'(gate_a_o), 1);
        force_off_i = 1'b1;
        #1;
        chk("R8 all low same cycle", int'({gate_a_o, gate_b_o, gate_c_o, gate_d_o}), 0);
        tick();
        chk("R8 held low", int'({gate_a_o, gate_b_o, gate_c_o, gate_d_o}), 0);
        force_off_i = 1'b0;
        #1;
        chk("R8 resume A/B/C/D", int'({gate_a_o, gate_b_o, gate_c_o, gate_d_o}), 4'b1010);

        summary();
    end
endmodule